// File: doc/BRIEF.md
# SDRAM Data-Pin Timing Pipeline

This block models when the data pins of a synchronous DRAM are used. Already-decoded read, write and burst-stop strobes come in, along with a read-latency select, a burst-length select, the data mask and the clock enable. Write beats are flagged in the same cycle as the write command, so an array stand-in can capture data at once. Read beats go through a short latency line and come out as a data-valid flag and an output-enable flag. Each beat carries its position within the burst.

The mask acts on the two directions with different delays. It blocks a write beat in the cycle where it is sampled. It turns off the read drivers two clocks after it is sampled, but the data-valid flag is left alone. A low clock enable is seen one edge later. From then on the whole block is frozen: burst counters, the latency line and the mask line all hold their values, which stretches any burst in flight. Command strobes sampled while frozen are ignored.

Top module: `sdram_dq_timing`

## Requirements
- R1: `burst_sel` selects the burst length: 00 gives 1 beat, 01 gives 2, 10 gives 4 and 11 gives 8. The beats of a burst carry beat indices 0, 1, 2 and so on up to length-1, one per active cycle.
- R2: A write beat is flagged on `wr_stb` in the same cycle as the accepted write command, with zero latency. Later beats follow on consecutive active cycles.
- R3: `lat_sel`=0 selects a read latency of 2 and `lat_sel`=1 selects 3. For a read beat issued at active edge n, `rd_valid` is high in the cycle that ends at active edge n+latency.
- R4: If `dqm` is high in a cycle that carries a write beat, `wr_stb` stays low in that same cycle. The burst still advances.
- R5: If `dqm` is high at active edge m, `rd_oe` is low in the cycle that ends at active edge m+2. `rd_valid` is not affected by the mask.
- R6: If `cke` is low at an edge, the next edge is frozen. On a frozen edge no state changes, `wr_stb` is low in the cycle before it, and command strobes are ignored, so bursts stretch by one cycle for each frozen edge. Out of reset the first edge is active.
- R7: An accepted `term_cmd` ends the burst in progress. Its own cycle and later cycles carry no new beat. Read beats issued earlier still come out.
- R8: A new read or write command cuts off any burst in progress and starts a fresh count. When strobes coincide, `term_cmd` beats `wr_cmd`, and `wr_cmd` beats `rd_cmd`.
- R9: After reset `rd_valid`, `rd_oe` and `wr_stb` are low. `rd_oe` is low in every cycle that has no read beat due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, takes effect one edge later |
| rd_cmd | input | 1 | Decoded read command strobe |
| wr_cmd | input | 1 | Decoded write command strobe |
| term_cmd | input | 1 | Decoded burst-stop strobe |
| lat_sel | input | 1 | Read latency select (0: 2, 1: 3) |
| burst_sel | input | 2 | Burst length select |
| dqm | input | 1 | Data mask |
| rd_valid | output | 1 | A read beat is on the data pins this cycle |
| rd_oe | output | 1 | Read drivers enabled this cycle |
| rd_beat | output | 3 | Beat index of the current read beat |
| wr_stb | output | 1 | Capture write data this cycle |
| wr_beat | output | 3 | Beat index of the current write beat |

## Verification
The bench builds the block with its default constants: a 3-bit beat index, which allows bursts of up to eight beats, and read latencies of 2 and 3. At that size it can sweep all four burst lengths under both latencies, each against nine stimulus shapes. The shapes cover a plain read, a plain write, alternating masks in each direction, freeze windows inside read and write bursts, a burst stop, interrupting commands and coinciding strobes. The expected values come from a schedule kept in the bench and indexed by active-edge number.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int unsigned BEAT_W  = 3;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = LAT_MIN + 1;
  localparam int unsigned MASK_D  = 2;

  typedef struct packed {
    logic              v;
    logic [BEAT_W-1:0] idx;
  } slot_t;

  function automatic int unsigned beats_of(input logic [SEL_W-1:0] sel);
    return 32'd1 << sel;
  endfunction

  function automatic logic [BEAT_W-1:0] last_left(input logic [SEL_W-1:0] sel);
    return BEAT_W'(beats_of(sel) - 1);
  endfunction
endpackage

// File: rtl/sdp_adv_gate.sv
module sdp_adv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic rd_req,
  input  logic wr_req,
  input  logic term_req,
  output logic adv,
  output logic acc_rd,
  output logic acc_wr,
  output logic acc_term
);
  logic cke_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  assign adv      = cke_q;
  assign acc_term = adv & term_req;
  assign acc_wr   = adv & wr_req & ~term_req;
  assign acc_rd   = adv & rd_req & ~term_req & ~wr_req;

  // R6: a strobe presented after a low clock enable is never accepted
  p_frozen_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !(acc_rd || acc_wr || acc_term));
endmodule

// File: rtl/sdp_burst_seq.sv
module sdp_burst_seq
  import sdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              start,
  input  logic              kill,
  input  logic [SEL_W-1:0]  len_sel,
  output logic              beat_now,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              busy
);
  logic [BEAT_W-1:0] left_q;
  logic [BEAT_W-1:0] idx_q;
  logic              cont;

  assign busy     = (left_q != '0);
  assign cont     = adv & busy & ~kill & ~start;
  assign beat_now = start | cont;
  assign beat_idx = start ? '0 : idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      idx_q  <= '0;
    end else if (start) begin
      left_q <= last_left(len_sel);
      idx_q  <= BEAT_W'(1);
    end else if (kill) begin
      left_q <= '0;
    end else if (cont) begin
      left_q <= left_q - BEAT_W'(1);
      idx_q  <= idx_q + BEAT_W'(1);
    end
  end

  // R6: a frozen edge leaves the burst count untouched
  p_stretch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !adv) |=> ($stable(left_q) && $stable(idx_q)));
  // R1: a single-beat burst leaves nothing pending
  p_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && len_sel == '0) |=> !busy);
  // R7: a kill empties the burst
  p_kill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !start) |=> !busy);
endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe
  import sdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              issue,
  input  logic [BEAT_W-1:0] issue_idx,
  input  logic              lat_sel,
  input  logic              mask,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic [BEAT_W-1:0] rd_idx
);
  slot_t              stage_q [LAT_MAX];
  logic [MASK_D-1:0]  mask_q;
  slot_t              out_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(LAT_MAX); i++) stage_q[i] <= '0;
      mask_q <= '0;
    end else if (adv) begin
      stage_q[0] <= '{v: issue, idx: issue_idx};
      for (int i = 1; i < int'(LAT_MAX); i++) stage_q[i] <= stage_q[i-1];
      mask_q <= {mask_q[MASK_D-2:0], mask};
    end
  end

  assign out_s    = lat_sel ? stage_q[LAT_MAX-1] : stage_q[LAT_MIN-1];
  assign rd_valid = out_s.v;
  assign rd_idx   = out_s.idx;
  assign rd_oe    = out_s.v & ~mask_q[MASK_D-1];

  // R6: nothing in the read line moves on a frozen edge
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(stage_q[LAT_MAX-1]) && $stable(stage_q[LAT_MIN-1]) && $stable(mask_q)));
  // R3: an issued beat reaches the latency-2 tap after one more active edge
  p_pipe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue ##1 adv |=> stage_q[LAT_MIN-1].v);
  // R5: the mask turns the drivers off two active edges later
  p_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask && adv) ##1 adv |=> !rd_oe);
endmodule

// File: rtl/sdram_dq_timing.sv
module sdram_dq_timing
  import sdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              rd_cmd,
  input  logic              wr_cmd,
  input  logic              term_cmd,
  input  logic              lat_sel,
  input  logic [SEL_W-1:0]  burst_sel,
  input  logic              dqm,
  output logic              rd_valid,
  output logic              rd_oe,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              wr_stb,
  output logic [BEAT_W-1:0] wr_beat
);
  logic              adv;
  logic              acc_rd;
  logic              acc_wr;
  logic              acc_term;
  logic              rd_now;
  logic [BEAT_W-1:0] rd_now_idx;
  logic              rd_busy;
  logic              wr_now;
  logic              wr_busy;

  sdp_adv_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .rd_req(rd_cmd), .wr_req(wr_cmd), .term_req(term_cmd),
    .adv(adv), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_term(acc_term)
  );

  sdp_burst_seq u_rd_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .start(acc_rd), .kill(acc_wr | acc_term), .len_sel(burst_sel),
    .beat_now(rd_now), .beat_idx(rd_now_idx), .busy(rd_busy)
  );

  sdp_burst_seq u_wr_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .start(acc_wr), .kill(acc_rd | acc_term), .len_sel(burst_sel),
    .beat_now(wr_now), .beat_idx(wr_beat), .busy(wr_busy)
  );

  sdp_rd_pipe u_rd_pipe (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .issue(rd_now), .issue_idx(rd_now_idx),
    .lat_sel(lat_sel), .mask(dqm),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .rd_idx(rd_beat)
  );

  assign wr_stb = wr_now & ~dqm;

  // R2: an accepted unmasked write is flagged in its own cycle
  p_wr_zero_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && !dqm) |-> wr_stb);
  // R6: no write strobe in the cycle after a low clock enable
  p_wr_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> !wr_stb);
  // R8: a write command clears any read burst left
  p_wr_cuts_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> !rd_busy);
  // R8: a read command clears any write burst left
  p_rd_cuts_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rd |=> !wr_busy);
endmodule

// File: tb/sdram_dq_timing_tb.sv
module sdram_dq_timing_tb_top;
  localparam int CLK_P = 10;
  localparam int N     = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1, rd_cmd = 1'b0, wr_cmd = 1'b0, term_cmd = 1'b0;
  logic       lat_sel = 1'b0, dqm = 1'b0;
  logic [1:0] burst_sel = 2'b00;
  logic       rd_valid, rd_oe, wr_stb;
  logic [2:0] rd_beat, wr_beat;

  int checks = 0, bad = 0, cyc = 0;
  bit done = 0;

  bit iss_v [N];
  int iss_i [N];
  bit wis_v [N];
  int wis_i [N];
  bit dq_rec [N];
  int a = 0;
  bit adv_m = 1;

  always #(CLK_P/2) clk = ~clk;

  sdram_dq_timing dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .rd_cmd(rd_cmd), .wr_cmd(wr_cmd),
    .term_cmd(term_cmd), .lat_sel(lat_sel), .burst_sel(burst_sel), .dqm(dqm),
    .rd_valid(rd_valid), .rd_oe(rd_oe), .rd_beat(rd_beat),
    .wr_stb(wr_stb), .wr_beat(wr_beat)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input bit r, input bit w, input bit t, input bit m, input bit k,
                      input string rtag, input string wtag);
    int e, src, lat;
    bit ev, eoe, ew;
    @(negedge clk);
    cyc++;
    lat = 2 + int'(lat_sel);
    src = a - lat + 1;
    ev  = (src >= 1) ? iss_v[src % N] : 1'b0;
    eoe = ev && !((a >= 2) ? dq_rec[(a-1) % N] : 1'b0);
    chk(rtag, "rd_valid", int'(rd_valid), int'(ev));
    chk(eoe ? rtag : "R9", "rd_oe", int'(rd_oe), int'(eoe));
    if (ev) chk("R1", "rd_beat", int'(rd_beat), iss_i[src % N]);
    rd_cmd = r; wr_cmd = w; term_cmd = t; dqm = m; cke = k;
    #1;
    ew = 1'b0;
    e  = a + 1;
    if (adv_m) begin
      iss_v[(e+16) % N] = 0; wis_v[(e+16) % N] = 0;
      if (t || w || r) begin
        for (int j = 0; j < 9; j++) begin iss_v[(e+j) % N] = 0; wis_v[(e+j) % N] = 0; end
        if (!t && w)
          for (int j = 0; j < (1 << burst_sel); j++) begin wis_v[(e+j) % N] = 1; wis_i[(e+j) % N] = j; end
        else if (!t && r)
          for (int j = 0; j < (1 << burst_sel); j++) begin iss_v[(e+j) % N] = 1; iss_i[(e+j) % N] = j; end
      end
      ew = wis_v[e % N] && !m;
    end
    chk(wtag, "wr_stb", int'(wr_stb), int'(ew));
    if (ew) chk("R1", "wr_beat", int'(wr_beat), wis_i[e % N]);
    @(posedge clk);
    if (adv_m) begin a = e; dq_rec[a % N] = m; end
    adv_m = k;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin iss_v[i] = 0; wis_v[i] = 0; dq_rec[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9", "reset rd_valid", int'(rd_valid), 0);
    chk("R9", "reset rd_oe", int'(rd_oe), 0);
    chk("R9", "reset wr_stb", int'(wr_stb), 0);
    for (int l = 0; l < 2; l++) begin
      for (int b = 0; b < 4; b++) begin
        for (int p = 0; p < 9; p++) begin
          string rt, wt;
          @(negedge clk);
          lat_sel = l[0]; burst_sel = b[1:0];
          case (p)
            0: begin rt = "R3"; wt = "R9"; end
            1: begin rt = "R9"; wt = "R2"; end
            2: begin rt = "R5"; wt = "R9"; end
            3: begin rt = "R9"; wt = "R4"; end
            4: begin rt = "R6"; wt = "R9"; end
            5: begin rt = "R6"; wt = "R6"; end
            6: begin rt = "R7"; wt = "R7"; end
            default: begin rt = "R8"; wt = "R8"; end
          endcase
          for (int c = 0; c < 20; c++) begin
            bit r, w, t, m, k;
            r = 0; w = 0; t = 0; m = 0; k = 1;
            case (p)
              0: r = (c == 0);
              1: w = (c == 0);
              2: begin r = (c == 0); m = c[0]; end
              3: begin w = (c == 0); m = c[0]; end
              4: begin r = (c == 0); k = !(c == 2 || c == 3); end
              5: begin w = (c == 0); k = !(c == 2); r = (c == 3); end
              6: begin r = (c == 0); t = (c == 2) || (c == 10); w = (c == 8); end
              7: begin w = (c == 0) || (c == 5); r = (c == 2); end
              default: begin r = (c == 0) || (c == 4); w = (c == 0); t = (c == 4) || (c == 9); r = r || (c == 9); end
            endcase
            step(r, w, t, m, k, rt, wt);
          end
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule